// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block gathers the data bytes of one page write from a serial-memory protocol engine. It holds them in registers the size of one page until the host ends the transfer. When the protocol engine decodes the byte address, it loads the start location with a strobe. Each data byte it then accepts goes into the buffer at the current in-page offset. Only that offset advances, and it wraps at the page boundary. When a transfer carries more bytes than the page holds, the later bytes therefore replace the earlier ones. The page number never changes during a transfer.

On STOP, the buffer hands the whole page to the storage array in a single commit. A per-byte valid mask comes with it, so only the locations that were actually loaded get programmed. A timed program cycle follows. Its length is a parameter counted in clocks, and busy stays high for all of it. The protocol engine uses busy to withhold acknowledges while the host polls. A STOP that comes with no buffered bytes, or while write protect is asserted, starts no program cycle. A write-protected STOP also discards any bytes in the buffer.

Top module: `eepw_top`

## Requirements
- R1: After a synchronous active-low reset, busy and the array write enable are low, and the valid mask is all zeros.
- R2: An address strobe taken while idle loads the page number from the upper address bits and the in-page offset from the low log2(PAGE_BYTES) bits. Accepted data bytes never change the page number, and the commit presents that page number on the array page output.
- R3: A data byte is accepted when the load strobe is high, the block is idle and write protect is low. It is stored at the current offset and sets that offset's mask bit. The offset then advances by one, modulo PAGE_BYTES.
- R4: When more than PAGE_BYTES bytes are accepted before STOP, the offset wraps. A later byte replaces the earlier byte held at the same offset.
- R5: The array write enable stays low while bytes are being accepted. Buffered data reaches the array only during a program cycle.
- R6: A STOP taken while idle, with write protect low and at least one mask bit set, raises busy on the next clock. Busy then stays high for exactly PROG_CYCLES clocks.
- R7: The array write enable is high for exactly one clock, the last clock of busy. During that clock the array data bus holds byte i in bits [8i+7:8i], and mask bit i is set exactly when offset i was loaded.
- R8: When the program cycle ends, the mask is all zeros, so a following STOP with no new bytes starts nothing.
- R9: A STOP with an empty mask leaves busy and the array write enable low.
- R10: While write protect is high, data bytes are refused. A STOP taken while write protect is high starts no program cycle and clears the mask.
- R11: While busy, the load strobe, the address strobe and STOP are ignored. They neither alter the committed page nor lengthen the program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_set_i | input | 1 | Strobe: load start address |
| addr_i | input | ADDR_W | Start byte address |
| load_i | input | 1 | Strobe: data byte received |
| load_data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | STOP condition seen on the bus |
| wp_i | input | 1 | Write-protect inhibit |
| busy_o | output | 1 | Program cycle in progress |
| arr_we_o | output | 1 | Array page write enable |
| arr_page_o | output | ADDR_W-log2(PAGE_BYTES) | Page number for the array write |
| arr_data_o | output | PAGE_BYTES*DATA_W | Whole page of buffered data |
| arr_mask_o | output | PAGE_BYTES | Per-byte write mask |

## Verification
The bench builds the block with an 11-bit address, a 16-byte page and a 20-clock program cycle. These values are short enough that many random transfers run in a few thousand clocks. Transfers of up to 40 bytes wrap a page more than twice, so the wrap and overwrite behaviour is exercised. The offset's top bit comes into play, and the page field is 7 bits wide. With 20 clocks of busy, strobes can be injected in the middle of a program cycle, and the exact busy length can be counted at the ports.

// File: rtl/eepw_pkg.sv
`timescale 1ns/1ps
// Shared types for the page write buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package eepw_pkg;

    // What a STOP taken in the current cycle does
    typedef enum logic [1:0] {
        STOP_NONE    = 2'd0,   // no STOP, busy, or nothing buffered
        STOP_COMMIT  = 2'd1,   // start a program cycle
        STOP_DISCARD = 2'd2    // write protected: drop the buffer
    } stop_act_e;

endpackage

// File: rtl/eepw_addr_ctr.sv
`timescale 1ns/1ps
// Address tracker for the page write buffer.
// Holds the page number and the in-page offset. A set strobe loads both.
// An advance pulse steps only the offset, which wraps at the page size.
// Assumes: PAGE_W >= 1, and the top never asserts set and adv together.
module eepw_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 4,
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  off_o
);

    // Load a start address or step the offset, wrapping inside the page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_o <= '0;
            off_o  <= '0;
        end else if (set_i) begin
            page_o <= addr_i[ADDR_W-1:OFF_W];
            off_o  <= addr_i[OFF_W-1:0];
        end else if (adv_i) begin
            off_o  <= off_o + 1'b1;
        end
    end

    // R3
    off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !set_i) |=> (off_o == OFF_W'($past(off_o) + 1'b1)));

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !set_i) |=> $stable(page_o));

endmodule

// File: rtl/eepw_page_buf.sv
`timescale 1ns/1ps
// Page-sized byte store with a per-byte valid mask.
// A write puts one byte at the given offset and marks that offset valid.
// A clear empties the mask. Byte contents stay in place and are masked off.
// Assumes: PAGE_BYTES is a power of two and OFF_W = log2(PAGE_BYTES).
module eepw_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [OFF_W-1:0]             wr_off_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic                         clr_i,
    output logic [PAGE_BYTES*DATA_W-1:0] data_o,
    output logic [PAGE_BYTES-1:0]        mask_o
);

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        logic hit;
        assign hit = wr_i && (wr_off_i == OFF_W'(i));

        // Capture the byte addressed by the current offset
        always_ff @(posedge clk) begin
            if (!rst_n)   data_o[i*DATA_W +: DATA_W] <= '0;
            else if (hit) data_o[i*DATA_W +: DATA_W] <= wr_data_i;
        end

        // Track whether this location has been loaded since the last clear
        always_ff @(posedge clk) begin
            if (!rst_n)      mask_o[i] <= 1'b0;
            else if (clr_i)  mask_o[i] <= 1'b0;
            else if (hit)    mask_o[i] <= 1'b1;
        end
    end

    // R3
    mark_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> mask_o[$past(wr_off_i)]);

    // R4
    byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (data_o[$past(wr_off_i)*DATA_W +: DATA_W] == $past(wr_data_i)));

endmodule

// File: rtl/eepw_prog_timer.sv
`timescale 1ns/1ps
// Program-cycle timer. A start pulse taken while idle raises busy
// for PROG_CYCLES clocks. last_o marks the final busy clock.
// Assumes: PROG_CYCLES >= 1. A start pulse while busy is ignored.
module eepw_prog_timer #(
    parameter int PROG_CYCLES = 1000,
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);

    logic [CNT_W-1:0] remain;

    // Count down the clocks left in the program cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            remain <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                busy_o <= 1'b1;
                remain <= CNT_W'(PROG_CYCLES - 1);
            end
        end else if (remain == '0) begin
            busy_o <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end

    // Flag the final clock of the program cycle
    always_comb last_o = busy_o && (remain == '0);

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> busy_o);

    // R7
    end_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !busy_o);

endmodule

// File: rtl/eepw_top.sv
`timescale 1ns/1ps
// Page write buffer top. Sits between the protocol engine and the
// storage array. It collects the bytes of a page write and commits them
// when STOP arrives, then runs a timed program cycle with busy high.
// Assumes: strobes are one clock wide, and address and load strobes never
// coincide. PAGE_BYTES is a power of two below 2**ADDR_W.
module eepw_top
    import eepw_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 16,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         addr_set_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         load_i,
    input  logic [DATA_W-1:0]            load_data_i,
    input  logic                         stop_i,
    input  logic                         wp_i,
    output logic                         busy_o,
    output logic                         arr_we_o,
    output logic [PAGE_W-1:0]            arr_page_o,
    output logic [PAGE_BYTES*DATA_W-1:0] arr_data_o,
    output logic [PAGE_BYTES-1:0]        arr_mask_o
);

    logic             accept;
    logic             set_addr;
    logic             prog_last;
    logic             buf_clr;
    logic [OFF_W-1:0] cur_off;
    stop_act_e        stop_act;

    // Qualify the strobes: nothing changes during a program cycle
    always_comb begin
        accept   = load_i && !busy_o && !wp_i;
        set_addr = addr_set_i && !busy_o;
    end

    // Decide what a STOP does in this cycle
    always_comb begin
        if (!stop_i || busy_o)    stop_act = STOP_NONE;
        else if (wp_i)            stop_act = STOP_DISCARD;
        else if (|arr_mask_o)     stop_act = STOP_COMMIT;
        else                      stop_act = STOP_NONE;
    end

    // Empty the buffer after a commit or on a protected STOP
    always_comb buf_clr = prog_last || (stop_act == STOP_DISCARD);

    eepw_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_addr),
        .addr_i (addr_i),
        .adv_i  (accept),
        .page_o (arr_page_o),
        .off_o  (cur_off)
    );

    eepw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (accept),
        .wr_off_i  (cur_off),
        .wr_data_i (load_data_i),
        .clr_i     (buf_clr),
        .data_o    (arr_data_o),
        .mask_o    (arr_mask_o)
    );

    eepw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (stop_act == STOP_COMMIT),
        .busy_o  (busy_o),
        .last_o  (prog_last)
    );

    // Commit the page to the array on the last clock of the program cycle
    always_comb arr_we_o = prog_last;

    // R5
    we_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    // R8
    mask_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |=> (arr_mask_o == '0));

    // R9
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && (arr_mask_o == '0)) |=> !busy_o);

    // R10
    wp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && wp_i && !busy_o) |=> (!busy_o && (arr_mask_o == '0)));

    // R11
    frozen_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !arr_we_o) |=> ($stable(arr_mask_o) && $stable(arr_data_o) && $stable(arr_page_o)));

endmodule

// File: tb/eepw_top_tb.sv
`timescale 1ns/1ps
// Bench for eepw_top: directed corner cases plus seeded random transfers,
// all checked against a reference model of the page kept in the bench.
module eepw_top_tb;

    localparam int AW = 11;
    localparam int PB = 16;
    localparam int DW = 8;
    localparam int PC = 20;
    localparam int OW = 4;
    localparam int PW = AW - OW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_set = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic              load = 1'b0;
    logic [DW-1:0]     din = '0;
    logic              stop = 1'b0;
    logic              wp = 1'b0;
    logic              busy;
    logic              we;
    logic [PW-1:0]     page;
    logic [PB*DW-1:0]  data;
    logic [PB-1:0]     mask;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0]     m_buf [PB];
    logic [PB-1:0]     m_mask = '0;
    logic [PW-1:0]     m_page = '0;
    logic [OW-1:0]     m_off = '0;

    always #2.5 clk = ~clk;

    eepw_top #(.ADDR_W(AW), .PAGE_BYTES(PB), .DATA_W(DW), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_set_i(addr_set), .addr_i(addr),
        .load_i(load), .load_data_i(din), .stop_i(stop), .wp_i(wp),
        .busy_o(busy), .arr_we_o(we), .arr_page_o(page),
        .arr_data_o(data), .arr_mask_o(mask)
    );

    task automatic chk(input bit ok, input string req, input logic [PB*DW-1:0] act, input logic [PB*DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [PB*DW-1:0] exp_bus();
        logic [PB*DW-1:0] b = '0;
        for (int i = 0; i < PB; i++) if (m_mask[i]) b[i*DW +: DW] = m_buf[i];
        return b;
    endfunction

    function automatic logic [PB*DW-1:0] widen(input logic [PB-1:0] m);
        logic [PB*DW-1:0] b = '0;
        for (int i = 0; i < PB; i++) if (m[i]) b[i*DW +: DW] = '1;
        return b;
    endfunction

    task automatic set_addr(input logic [AW-1:0] a);
        addr_set = 1'b1; addr = a;
        @(negedge clk);
        addr_set = 1'b0;
        m_page = a[AW-1:OW];
        m_off  = a[OW-1:0];
    endtask

    task automatic put(input logic [DW-1:0] d);
        load = 1'b1; din = d;
        @(negedge clk);
        load = 1'b0;
        chk(!we, "R5 no array write during loads", PB*DW'(we), '0);
        if (!wp) begin
            m_buf[m_off] = d;
            m_mask[m_off] = 1'b1;
            m_off = m_off + 1'b1;
        end
    endtask

    // STOP expected to start nothing (R9/R10/R8 paths)
    task automatic stop_idle(input string req);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        if (wp) m_mask = '0;
        for (int k = 0; k < 3; k++) begin
            chk(!busy && !we, req, PB*DW'({busy, we}), '0);
            @(negedge clk);
        end
    endtask

    // STOP expected to commit; optionally inject strobes while busy (R11)
    task automatic stop_commit(input bit inject);
        int n = 0;
        int wes = 0;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(busy, "R6 busy rises after STOP", PB*DW'(busy), 1);
        while (busy && n < 100) begin
            n++;
            if (we) begin
                wes++;
                chk(n == PC, "R7 write enable on last busy clock", n, PC);
                chk(page == m_page, "R2 committed page", page, m_page);
                chk(mask == m_mask, "R7 mask of loaded offsets", mask, m_mask);
                chk((data & widen(m_mask)) == exp_bus(), "R4 committed page data",
                    data & widen(m_mask), exp_bus());
            end
            if (inject && n == 2) begin
                load = 1'b1; din = 8'hA5; stop = 1'b1;
            end
            if (inject && n == 3) begin
                load = 1'b0; stop = 1'b0; addr_set = 1'b1; addr = '1;
            end
            if (inject && n == 4) addr_set = 1'b0;
            @(negedge clk);
        end
        chk(n == PC, inject ? "R11 busy length with injected strobes" : "R6 busy length", n, PC);
        chk(wes == 1, "R7 single write pulse", wes, 1);
        m_mask = '0;
        chk(mask == '0, "R8 mask cleared after program", mask, '0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < PB; i++) m_buf[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !we && mask == '0, "R1 reset state", PB*DW'({busy, we, mask}), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: STOP with nothing buffered
        set_addr(11'h123);
        stop_idle("R9 empty STOP starts nothing");

        // R3: single byte at the last in-page offset, then wrap to 0
        set_addr(11'h2AF);
        put(8'h11);
        put(8'h22);
        stop_commit(1'b0);

        // R8: a second STOP with no new bytes
        stop_idle("R8 STOP after commit starts nothing");

        // R4: overfill from offset 5 with 20 bytes
        set_addr(11'h4C5);
        for (int i = 0; i < 20; i++) put(8'(8'h40 + i));
        stop_commit(1'b0);

        // R10: loads refused and STOP blocked while write protected
        set_addr(11'h010);
        wp = 1'b1;
        put(8'h99);
        put(8'h98);
        stop_idle("R10 protected STOP starts nothing");
        wp = 1'b0;
        stop_idle("R10 refused bytes were not buffered");

        // R10: buffered bytes discarded by a protected STOP
        set_addr(11'h030);
        put(8'h77);
        wp = 1'b1;
        stop_idle("R10 protected STOP with data");
        wp = 1'b0;
        stop_idle("R10 discarded buffer stays empty");

        // R11: strobes during the program cycle are ignored
        set_addr(11'h7F8);
        for (int i = 0; i < 3; i++) put(8'(8'hC0 + i));
        stop_commit(1'b1);

        // Random transfers
        for (int t = 0; t < 30; t++) begin
            int cnt;
            set_addr(AW'($urandom));
            cnt = 1 + ($urandom % 40);
            for (int i = 0; i < cnt; i++) put(8'($urandom));
            stop_commit(1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule